// File: doc/BRIEF.md
# Accumulator Field Extractor

This block reads a 64-bit signed accumulator and returns a 32-bit result by one of two methods. The position method takes the top bit of a field from a 6-bit pointer held in the low bits of a control word. It returns `size+1` bits that end at that pointer, zero-extended. It can also move the pointer down past the bits it has consumed. A run of such operations can therefore unpack a stream of variable-length fields from the accumulator. The shift method shifts the accumulator right arithmetically by 0 to 31 places, with optional rounding. It reports when the value does not fit a signed 32-bit word and can clamp the result to that range.

The caller presents the accumulator, an amount, the mode selects and the current control word together with a one-cycle strobe. On the next clock edge the block registers the result and a copy of the control word with the affected fields changed. Every other control bit is copied through unchanged. Writing the accumulator is the caller's job.

Top module: `fx_acc_extract`

## Requirements
- R1: While reset is asserted and after it is released, `res_out`, `ctl_out` and `res_valid` are all zero until the first strobe.
- R2: A strobe on `op_valid` updates `res_out` and `ctl_out` on the next rising clock edge, and `res_valid` is high for exactly that one cycle. Without a strobe, both outputs hold their values.
- R3: Only bits [4:0] of the 8-bit `amt` input are used, as the field size minus one or as the shift distance. Bits [7:5] have no effect.
- R4: Position method (`op_kind`=0): the pointer is `ctl_in[5:0]`. When pointer ≥ size, the result is accumulator bits [pointer : pointer−size], zero-extended to 32 bits, and control bit 14 (extract-failed) is cleared.
- R5: Position method with pointer < size: the result is 0, control bit 14 is set, and the pointer field keeps its value.
- R6: When `dec_en` is set and the position extract succeeds, the pointer field becomes pointer−size−1, and wraps to 63 when pointer equals size. Without `dec_en`, the pointer is copied unchanged.
- R7: Shift method (`op_kind`=1): a distance of 0 passes the accumulator through. A nonzero distance shifts it right arithmetically, and the result is the low 32 bits.
- R8: With `rnd_en`, 2^(distance−1) is added before the shift. If that addition turns a positive accumulator negative, control bit 23 (overflow) is set. With `sat_en` also set, the pre-shift value becomes the largest positive 64-bit value.
- R9: If the incoming accumulator lies outside the signed 32-bit range, control bit 23 is set. With `sat_en`, the result is then clamped to 0x7FFFFFFF or 0x80000000. The shift method never clears bit 23.
- R10: The shift method copies bits [5:0] and bit 14 from `ctl_in`. The position method copies bit 23. Both methods copy all other control bits from `ctl_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | One-cycle operation strobe |
| op_kind | input | 1 | 0 = position extract, 1 = shift extract |
| dec_en | input | 1 | Move the pointer down after a position extract |
| rnd_en | input | 1 | Round before the shift |
| sat_en | input | 1 | Clamp the shift result to signed 32 bits |
| acc_in | input | 64 | Accumulator value |
| amt | input | 8 | Field size minus one, or shift distance (low 5 bits used) |
| ctl_in | input | 32 | Current control word |
| res_out | output | 32 | Registered extraction result |
| ctl_out | output | 32 | Registered updated control word |
| res_valid | output | 1 | High for the cycle after a strobe |

## Verification
The bench builds the block with its default parameters: a 64-bit accumulator, a 32-bit result and 32-bit control word, and a 5-bit amount field. These values bring every pointer from 0 to 63 and every size and shift distance from 0 to 31 within reach. That covers the equal-pointer-and-size wrap to 63, the widest 32-bit field and the largest shift. Random operands mix small in-range accumulators with full-width ones, so both the fits and the does-not-fit paths of the clamp logic are exercised.

// File: rtl/fx_extract_pkg.sv
package fx_extract_pkg;

   typedef enum logic {
      KIND_POS   = 1'b0,
      KIND_SHIFT = 1'b1
   } ext_kind_e;

   typedef struct packed {
      logic        fail_bit;
      logic        ovf_bit;
   } ext_flags_t;

endpackage

// File: rtl/fx_pos_unit.sv
module fx_pos_unit #(
   parameter int ACC_W = 64,
   parameter int RES_W = 32,
   parameter int POS_W = 6,
   parameter int SZ_W  = 5
) (
   input  logic [ACC_W-1:0] acc,
   input  logic [POS_W-1:0] pos,
   input  logic [SZ_W-1:0]  size,
   input  logic             dec_en,
   output logic [RES_W-1:0] field,
   output logic             ok,
   output logic [POS_W-1:0] new_pos
);
   localparam int PAD_W = POS_W - SZ_W;

   logic [POS_W-1:0] size_ext;
   logic [POS_W-1:0] lo_bit;
   logic [ACC_W-1:0] shifted;

   assign size_ext = {{PAD_W{1'b0}}, size};
   assign ok       = (pos >= size_ext);
   assign lo_bit   = pos - size_ext;
   assign shifted  = acc >> lo_bit;

   // keep only bits 0..size of the shifted accumulator
   for (genvar i = 0; i < RES_W; i++) begin : g_mask
      localparam logic [SZ_W:0] IDX = (SZ_W+1)'(i);
      assign field[i] = ok && ({1'b0, size} >= IDX) && shifted[i];
   end

   // modulo-2^POS_W arithmetic gives the wrap to the top position
   always_comb begin
      if (dec_en && ok) new_pos = pos - size_ext - POS_W'(1);
      else              new_pos = pos;
   end
endmodule

// File: rtl/fx_shift_unit.sv
module fx_shift_unit #(
   parameter int ACC_W = 64,
   parameter int RES_W = 32,
   parameter int SH_W  = 5
) (
   input  logic [ACC_W-1:0] acc,
   input  logic [SH_W-1:0]  sa,
   input  logic             rnd_en,
   input  logic             sat_en,
   output logic [RES_W-1:0] res,
   output logic             ovf
);
   localparam int HI_W = ACC_W - RES_W + 1;
   localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic [RES_W-1:0] RES_MAX = {1'b0, {(RES_W-1){1'b1}}};
   localparam logic [RES_W-1:0] RES_MIN = {1'b1, {(RES_W-1){1'b0}}};

   logic [ACC_W-1:0]        one_sh;
   logic [ACC_W-1:0]        half;
   logic [ACC_W-1:0]        sum;
   logic signed [ACC_W-1:0] pre;
   logic signed [ACC_W-1:0] sh;
   logic                    acc_pos;
   logic                    rnd_wrap;
   logic                    acc_fits;
   logic                    sh_fits;
   logic [HI_W-1:0]         acc_hi;
   logic [HI_W-1:0]         sh_hi;

   assign one_sh   = ACC_W'(1) << sa;
   assign half     = rnd_en ? (one_sh >> 1) : '0;
   assign sum      = acc + half;
   assign acc_pos  = !acc[ACC_W-1] && (acc != '0);
   assign rnd_wrap = rnd_en && (sa != '0) && acc_pos && sum[ACC_W-1];

   always_comb begin
      if (rnd_wrap && sat_en) pre = ACC_MAX;
      else                    pre = sum;
   end

   assign sh = pre >>> sa;

   assign acc_hi   = acc[ACC_W-1:RES_W-1];
   assign sh_hi    = sh[ACC_W-1:RES_W-1];
   assign acc_fits = (&acc_hi) || !(|acc_hi);
   assign sh_fits  = (&sh_hi) || !(|sh_hi);
   assign ovf      = rnd_wrap || !acc_fits;

   always_comb begin
      if (ovf && sat_en && !sh_fits) res = sh[ACC_W-1] ? RES_MIN : RES_MAX;
      else                           res = sh[RES_W-1:0];
   end
endmodule

// File: rtl/fx_ctl_merge.sv
module fx_ctl_merge
   import fx_extract_pkg::*;
#(
   parameter int CTL_W    = 32,
   parameter int POS_W    = 6,
   parameter int FAIL_BIT = 14,
   parameter int OVF_BIT  = 23
) (
   input  logic [CTL_W-1:0] ctl_in,
   input  ext_kind_e        kind,
   input  logic             pos_ok,
   input  logic [POS_W-1:0] new_pos,
   input  logic             sh_ovf,
   output logic [CTL_W-1:0] ctl_next
);
   ext_flags_t flags;

   always_comb begin
      flags.fail_bit = ctl_in[FAIL_BIT];
      flags.ovf_bit  = ctl_in[OVF_BIT];
      ctl_next       = ctl_in;
      if (kind == KIND_POS) begin
         flags.fail_bit        = !pos_ok;
         ctl_next[POS_W-1:0]   = new_pos;
      end else begin
         flags.ovf_bit         = ctl_in[OVF_BIT] | sh_ovf;
      end
      ctl_next[FAIL_BIT] = flags.fail_bit;
      ctl_next[OVF_BIT]  = flags.ovf_bit;
   end
endmodule

// File: rtl/fx_acc_extract.sv
module fx_acc_extract
   import fx_extract_pkg::*;
#(
   parameter int ACC_W    = 64,
   parameter int RES_W    = 32,
   parameter int CTL_W    = 32,
   parameter int AMT_W    = 8,
   parameter int FAIL_BIT = 14,
   parameter int OVF_BIT  = 23
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic             op_kind,
   input  logic             dec_en,
   input  logic             rnd_en,
   input  logic             sat_en,
   input  logic [ACC_W-1:0] acc_in,
   input  logic [AMT_W-1:0] amt,
   input  logic [CTL_W-1:0] ctl_in,
   output logic [RES_W-1:0] res_out,
   output logic [CTL_W-1:0] ctl_out,
   output logic             res_valid
);
   localparam int POS_W = $clog2(ACC_W);
   localparam int SZ_W  = $clog2(RES_W);

   if ((1 << POS_W) != ACC_W) begin : g_bad_acc
      $error("ACC_W must be a power of two");
   end
   if ((1 << SZ_W) != RES_W) begin : g_bad_res
      $error("RES_W must be a power of two");
   end
   if (SZ_W >= POS_W || AMT_W < SZ_W) begin : g_bad_amt
      $error("amount field width does not suit ACC_W/RES_W");
   end
   if (FAIL_BIT < POS_W || OVF_BIT < POS_W || FAIL_BIT == OVF_BIT ||
       FAIL_BIT >= CTL_W || OVF_BIT >= CTL_W) begin : g_bad_bits
      $error("status bit positions overlap the pointer or the word");
   end

   ext_kind_e        kind;
   logic [SZ_W-1:0]  amt_m;
   logic [RES_W-1:0] pos_field;
   logic             pos_ok;
   logic [POS_W-1:0] new_pos;
   logic [RES_W-1:0] sh_res;
   logic             sh_ovf;
   logic [CTL_W-1:0] ctl_next;
   logic [RES_W-1:0] res_next;

   assign kind  = ext_kind_e'(op_kind);
   assign amt_m = amt[SZ_W-1:0];

   fx_pos_unit #(
      .ACC_W (ACC_W), .RES_W (RES_W), .POS_W (POS_W), .SZ_W (SZ_W)
   ) u_pos (
      .acc     (acc_in),
      .pos     (ctl_in[POS_W-1:0]),
      .size    (amt_m),
      .dec_en  (dec_en),
      .field   (pos_field),
      .ok      (pos_ok),
      .new_pos (new_pos)
   );

   fx_shift_unit #(
      .ACC_W (ACC_W), .RES_W (RES_W), .SH_W (SZ_W)
   ) u_shift (
      .acc    (acc_in),
      .sa     (amt_m),
      .rnd_en (rnd_en),
      .sat_en (sat_en),
      .res    (sh_res),
      .ovf    (sh_ovf)
   );

   fx_ctl_merge #(
      .CTL_W (CTL_W), .POS_W (POS_W), .FAIL_BIT (FAIL_BIT), .OVF_BIT (OVF_BIT)
   ) u_merge (
      .ctl_in   (ctl_in),
      .kind     (kind),
      .pos_ok   (pos_ok),
      .new_pos  (new_pos),
      .sh_ovf   (sh_ovf),
      .ctl_next (ctl_next)
   );

   assign res_next = (kind == KIND_POS) ? pos_field : sh_res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_out   <= '0;
         ctl_out   <= '0;
         res_valid <= 1'b0;
      end else begin
         res_valid <= op_valid;
         if (op_valid) begin
            res_out <= res_next;
            ctl_out <= ctl_next;
         end
      end
   end
endmodule

// File: rtl/fx_acc_extract_chk.sv
module fx_acc_extract_chk #(
   parameter int ACC_W    = 64,
   parameter int RES_W    = 32,
   parameter int CTL_W    = 32,
   parameter int AMT_W    = 8,
   parameter int FAIL_BIT = 14,
   parameter int OVF_BIT  = 23
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid,
   input logic             op_kind,
   input logic             dec_en,
   input logic [ACC_W-1:0] acc_in,
   input logic [CTL_W-1:0] ctl_in,
   input logic [RES_W-1:0] res_out,
   input logic [CTL_W-1:0] ctl_out,
   input logic             res_valid
);
   localparam int POS_W = $clog2(ACC_W);

   p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> res_valid);

   p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !res_valid);

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> ($stable(res_out) && $stable(ctl_out)));

   p_fail_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_kind) |=> (!ctl_out[FAIL_BIT] || res_out == '0));

   p_nodec_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_kind && !dec_en) |=>
         (ctl_out[POS_W-1:0] == $past(ctl_in[POS_W-1:0])));

   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind && ctl_in[OVF_BIT]) |=> ctl_out[OVF_BIT]);

   p_shift_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind) |=>
         (ctl_out[POS_W-1:0] == $past(ctl_in[POS_W-1:0]) &&
          ctl_out[FAIL_BIT] == $past(ctl_in[FAIL_BIT])));

   p_pos_keeps_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_kind) |=> (ctl_out[OVF_BIT] == $past(ctl_in[OVF_BIT])));

   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (!rst_n || (res_out == '0 && ctl_out == '0) || $past(op_valid)));

   logic unused_acc;
   assign unused_acc = ^acc_in;
endmodule

bind fx_acc_extract fx_acc_extract_chk #(
   .ACC_W (ACC_W), .RES_W (RES_W), .CTL_W (CTL_W),
   .AMT_W (AMT_W), .FAIL_BIT (FAIL_BIT), .OVF_BIT (OVF_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op_kind   (op_kind),
   .dec_en    (dec_en),
   .acc_in    (acc_in),
   .ctl_in    (ctl_in),
   .res_out   (res_out),
   .ctl_out   (ctl_out),
   .res_valid (res_valid)
);

// File: tb/fx_acc_extract_tb.sv
module fx_acc_extract_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic        op_kind = 1'b0;
   logic        dec_en = 1'b0;
   logic        rnd_en = 1'b0;
   logic        sat_en = 1'b0;
   logic [63:0] acc_in = '0;
   logic [7:0]  amt = '0;
   logic [31:0] ctl_in = '0;
   logic [31:0] res_out;
   logic [31:0] ctl_out;
   logic        res_valid;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fx_acc_extract u_dut (
      .clk (clk), .rst_n (rst_n), .op_valid (op_valid), .op_kind (op_kind),
      .dec_en (dec_en), .rnd_en (rnd_en), .sat_en (sat_en), .acc_in (acc_in),
      .amt (amt), .ctl_in (ctl_in), .res_out (res_out), .ctl_out (ctl_out),
      .res_valid (res_valid)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // position-method reference (R3..R6, R10)
   function automatic void ref_pos(input logic [63:0] acc, input logic [7:0] a,
                                   input logic [31:0] c, input logic dec,
                                   output logic [31:0] r, output logic [31:0] co);
      int p = int'(c[5:0]);
      int s = int'(a[4:0]);
      co = c;
      if (p >= s) begin
         r = 32'((acc >> (p - s)) & ((64'd1 << (s + 1)) - 64'd1));
         co[14] = 1'b0;
         if (dec) co[5:0] = 6'(p - s - 1);
      end else begin
         r = '0;
         co[14] = 1'b1;
      end
   endfunction

   // shift-method reference (R3, R7..R10)
   function automatic void ref_shift(input logic [63:0] acc, input logic [7:0] a,
                                     input logic [31:0] c, input logic rnd,
                                     input logic sat,
                                     output logic [31:0] r, output logic [31:0] co);
      longint sacc = longint'(acc);
      longint t = sacc;
      int s = int'(a[4:0]);
      bit ov = 1'b0;
      if (s > 0) begin
         if (rnd) begin
            t = sacc + (longint'(1) <<< (s - 1));
            if (sacc > 0 && t < 0) begin
               ov = 1'b1;
               if (sat) t = 64'sh7FFF_FFFF_FFFF_FFFF;
            end
         end
         t = t >>> s;
      end
      if (sacc > longint'(32'h7FFF_FFFF) || sacc < -longint'(64'h8000_0000)) ov = 1'b1;
      if (ov && sat && t > longint'(32'h7FFF_FFFF)) r = 32'h7FFF_FFFF;
      else if (ov && sat && t < -longint'(64'h8000_0000)) r = 32'h8000_0000;
      else r = t[31:0];
      co = c;
      if (ov) co[23] = 1'b1;
   endfunction

   task automatic run_op(input string req, input logic kind, input logic dec,
                         input logic rnd, input logic sat, input logic [63:0] acc,
                         input logic [7:0] a, input logic [31:0] c);
      logic [31:0] er, ec;
      @(negedge clk);
      op_valid = 1'b1; op_kind = kind; dec_en = dec; rnd_en = rnd;
      sat_en = sat; acc_in = acc; amt = a; ctl_in = c;
      if (kind) ref_shift(acc, a, c, rnd, sat, er, ec);
      else      ref_pos(acc, a, c, dec, er, ec);
      @(negedge clk);
      op_valid = 1'b0;
      check({req, " res"}, {32'd0, res_out}, {32'd0, er});
      check({req, " ctl"}, {32'd0, ctl_out}, {32'd0, ec});
      check("R2 valid pulse", {63'd0, res_valid}, 64'd1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] held_r, held_c;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      check("R1 reset res", {32'd0, res_out}, 64'd0);
      check("R1 reset ctl", {32'd0, ctl_out}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release valid", {63'd0, res_valid}, 64'd0);
      check("R1 after release res", {32'd0, res_out}, 64'd0);

      // directed corner cases
      run_op("R4 mid field", 1'b0, 1'b0, 1'b0, 1'b0, 64'h0123_4567_89AB_CDEF, 8'd7, 32'h0000_000F);
      run_op("R4 widest field", 1'b0, 1'b0, 1'b0, 1'b0, 64'hFEDC_BA98_7654_3210, 8'd31, 32'h0000_403F);
      run_op("R6 wrap to 63", 1'b0, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_000B, 8'd3, 32'h0080_4003);
      run_op("R6 decrement", 1'b0, 1'b1, 1'b0, 1'b0, 64'hFFFF_0000_FFFF_0000, 8'd9, 32'h0000_0028);
      run_op("R5 too small", 1'b0, 1'b1, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 8'd5, 32'h0080_0002);
      run_op("R3 upper amt bits", 1'b0, 1'b0, 1'b0, 1'b0, 64'h0000_0000_0000_00F0, 8'hE3, 32'h0000_0007);
      run_op("R7 zero shift", 1'b1, 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_8000_0001, 8'd0, 32'h0000_0011);
      run_op("R7 arith shift", 1'b1, 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FF00, 8'd4, 32'h0000_4000);
      run_op("R8 round pos", 1'b1, 1'b0, 1'b1, 1'b0, 64'd5, 8'd1, 32'h0);
      run_op("R8 round neg", 1'b1, 1'b0, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFB, 8'd1, 32'h0);
      run_op("R8 round wrap sat", 1'b1, 1'b0, 1'b1, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 8'd4, 32'h0000_0005);
      run_op("R9 no sat", 1'b1, 1'b0, 1'b0, 1'b0, 64'hFFFF_FF00_0000_0000, 8'd8, 32'h0);
      run_op("R9 sat neg", 1'b1, 1'b0, 1'b0, 1'b1, 64'hFFFF_FF00_0000_0000, 8'd0, 32'h0);
      run_op("R9 sat pos", 1'b1, 1'b0, 1'b0, 1'b1, 64'h0000_0001_0000_0000, 8'd0, 32'h0);
      run_op("R9 sticky", 1'b1, 1'b0, 1'b0, 1'b0, 64'd3, 8'd0, 32'h0080_0000);
      run_op("R10 pos keeps ovf", 1'b0, 1'b0, 1'b0, 1'b0, 64'd3, 8'd0, 32'hFF80_0000);

      // hold without strobe (R2)
      held_r = res_out; held_c = ctl_out;
      @(negedge clk);
      acc_in = 64'hDEAD_BEEF_0000_1111; ctl_in = 32'h1234_5678; amt = 8'd2;
      repeat (2) @(negedge clk);
      check("R2 hold res", {32'd0, res_out}, {32'd0, held_r});
      check("R2 hold ctl", {32'd0, ctl_out}, {32'd0, held_c});
      check("R2 valid low", {63'd0, res_valid}, 64'd0);

      // constrained random mix
      for (int n = 0; n < 400; n++) begin
         logic [63:0] ra;
         logic [31:0] rc;
         logic [7:0]  rm;
         logic        rk;
         rk = 1'($urandom);
         ra = {$urandom, $urandom};
         if (($urandom % 3) == 0) ra = {{32{ra[31]}}, ra[31:0]};
         rc = $urandom;
         rm = 8'($urandom);
         run_op(rk ? "R7 R8 R9 random shift" : "R4 R5 R6 random pos",
                rk, 1'($urandom), 1'($urandom), 1'($urandom), ra, rm, rc);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule